// File: doc/BRIEF.md
# SPI Chip-Select Timing Controller

This block sits between an SPI transaction sequencer and the pins. It keeps a parameter word for each of five chip-select ports and a shared port-state word. The port-state word holds the port selector and, for every port, the clock idle level, the clock phase, the chip-select idle level and the data idle level.

When the sequencer raises a request, the controller drives the selected port's chip-select to its active level. It then waits the programmed setup time before it allows clocking. At the end of the transaction it keeps the select asserted for the hold time. After the select is released, it holds off any new assertion for the programmed minimum inactive time. When the sequencer enables it, the controller also inserts a pause between bytes, sized from the hold setting. All times are counted in reference-clock cycles.

The selected port's clock-rate field is passed on to the bit-rate divider, together with a flag that says whether the setting is legal. The divider itself and the data shifting live elsewhere.

Top module: `spi_cs_timer`

## Requirements
- R1: After reset every chip-select line sits at its high idle level, all stored timing fields are zero and `clk_go` is low.
- R2: Bits 22:20 of the port-state word select the port. A request asserts only that port's line, driven to the inverse of its idle level, while every other line stays at its idle level. Selector values 5 to 7 never start a transaction.
- R3: The port-state groups are stored in reverse order. For port p, clock idle is bit 19-p, clock phase is bit 14-p, chip-select idle is bit 9-p and data idle is bit 4-p. `sclk_idle`, `sclk_phase` and `data_idle` show these bits for the current port.
- R4: Setup is held in bits 23:16 of a port's parameter word. `clk_go` rises exactly setup cycles after the chip-select asserts; with a setup of 0 it rises in the same cycle.
- R5: Hold is held in bits 15:8. After `last_done`, the chip-select stays asserted for exactly hold cycles with `clk_go` low.
- R6: The minimum inactive time is held in bits 7:0. After a release, the chip-select stays inactive for max(delay,1) cycles, even when a request is already pending.
- R7: When `gap_en` is high, a `byte_done` pulse drops `clk_go` for hold cycles. When `gap_en` is low, or hold is 0, clocking does not pause.
- R8: The port is latched when a transaction starts. Changing the selector during the transaction does not move the asserted line.
- R9: `rate_sel` shows bits 31:24 of the current port's word. `rate_ok` is high only when that value is a power of two from 1 to 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a port parameter word |
| cfg_port | input | 3 | Port whose parameter word is written |
| cfg_wdata | input | 32 | Parameter word: rate, setup, hold, inactive delay |
| st_we | input | 1 | Write strobe for the port-state word |
| st_wdata | input | 32 | Port-state word: selector and reversed idle/phase groups |
| txn_req | input | 1 | Sequencer requests a transaction (level) |
| byte_done | input | 1 | Sequencer finished a byte that is not the last one |
| last_done | input | 1 | Sequencer finished the last clock pulse |
| gap_en | input | 1 | Enables the pause between bytes |
| cs_o | output | 5 | Chip-select pin levels, one per port |
| clk_go | output | 1 | Sequencer may clock the bus |
| sclk_idle | output | 1 | Clock idle level of the current port |
| sclk_phase | output | 1 | Clock phase of the current port |
| data_idle | output | 1 | Data idle level of the current port |
| rate_sel | output | 8 | Clock-rate field of the current port |
| rate_ok | output | 1 | Clock-rate field is a legal power of two |

## Verification
A wrong count in the shared timer shows up within one transaction. The interval between the chip-select edge and `clk_go`, the length of the hold tail, or the inactive gap before the next select comes out longer or shorter by the error. A wrongly latched port index, or a misread reversed bit, shows on the first cycle of a transaction: the wrong line goes active, or the wrong idle and phase levels appear on the pins. The sweep covers every port with several setup, hold and delay values, so an off-by-one or a swapped port mapping appears within a few hundred cycles.

// File: rtl/spi_cst_pkg.sv
package spi_cst_pkg;
  localparam int FW = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RUN   = 3'd2,
    ST_GAP   = 3'd3,
    ST_HOLD  = 3'd4,
    ST_DELAY = 3'd5
  } cst_state_t;

  typedef struct packed {
    logic [FW-1:0] rate;
    logic [FW-1:0] setup;
    logic [FW-1:0] hold;
    logic [FW-1:0] delay;
  } port_param_t;
endpackage

// File: rtl/spi_cst_regs.sv
module spi_cst_regs
  import spi_cst_pkg::*;
#(
  parameter int NPORTS = 5,
  parameter int SELW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SELW-1:0]          cfg_port,
  input  port_param_t              cfg_wdata,
  input  logic                     st_we,
  input  logic [31:0]              st_wdata,
  output port_param_t [NPORTS-1:0] prm,
  output logic [SELW-1:0]          sel,
  output logic [NPORTS-1:0]        ck_idle,
  output logic [NPORTS-1:0]        ck_phase,
  output logic [NPORTS-1:0]        cs_idle,
  output logic [NPORTS-1:0]        d_idle
);
  localparam int STW = 4 * NPORTS + SELW;
  localparam logic [STW-1:0] ST_RST =
    {{(SELW + 2 * NPORTS){1'b0}}, {NPORTS{1'b1}}, {NPORTS{1'b0}}};

  logic [STW-1:0] st_q, st_d;

  // per-port parameter words, each with its own write enable
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic        wr_en;
    port_param_t prm_q;
    assign wr_en = cfg_we && (cfg_port == SELW'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prm_q <= '0;
      else if (wr_en) prm_q <= cfg_wdata;
    end
    assign prm[p] = prm_q;

    // groups are stored reversed: port 0 at the top bit of each group
    assign d_idle[p]   = st_q[NPORTS - 1 - p];
    assign cs_idle[p]  = st_q[2 * NPORTS - 1 - p];
    assign ck_phase[p] = st_q[3 * NPORTS - 1 - p];
    assign ck_idle[p]  = st_q[4 * NPORTS - 1 - p];
  end

  always_comb begin
    st_d = st_q;
    if (st_we) st_d = st_wdata[STW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RST;
    else        st_q <= st_d;
  end

  assign sel = st_q[4 * NPORTS +: SELW];
endmodule

// File: rtl/spi_cst_seq.sv
module spi_cst_seq
  import spi_cst_pkg::*;
#(
  parameter int NPORTS = 5,
  parameter int SELW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [SELW-1:0] sel,
  input  logic [FW-1:0]   setup,
  input  logic [FW-1:0]   hold,
  input  logic [FW-1:0]   delay,
  input  logic            byte_done,
  input  logic            last_done,
  input  logic            gap_en,
  output logic            busy,
  output logic            clk_go,
  output logic [SELW-1:0] act_port
);
  localparam int AGEW = 16;

  cst_state_t      st_q, st_d;
  logic [FW-1:0]   cnt_q, cnt_d;
  logic [SELW-1:0] act_q;
  logic            act_ld;
  logic            start_ok;
  cst_state_t      start_st, rel_st;
  logic [FW-1:0]   start_cnt, rel_cnt, hold_cnt;

  assign start_ok = req && (int'(sel) < NPORTS);

  always_comb begin
    start_st  = (setup == '0) ? ST_RUN : ST_SETUP;
    start_cnt = (setup == '0) ? '0 : setup - FW'(1);
    rel_st    = (delay == '0) ? ST_IDLE : ST_DELAY;
    rel_cnt   = (delay == '0) ? '0 : delay - FW'(1);
    hold_cnt  = (hold == '0) ? '0 : hold - FW'(1);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    act_ld = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_d = start_st; cnt_d = start_cnt; act_ld = 1'b1;
        end
      end
      ST_SETUP, ST_GAP: begin
        if (cnt_q == '0) st_d = ST_RUN;
        else             cnt_d = cnt_q - FW'(1);
      end
      ST_RUN: begin
        if (last_done) begin
          if (hold == '0) begin st_d = rel_st;  cnt_d = rel_cnt;  end
          else            begin st_d = ST_HOLD; cnt_d = hold_cnt; end
        end else if (byte_done && gap_en && (hold != '0)) begin
          st_d = ST_GAP; cnt_d = hold_cnt;
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin st_d = rel_st; cnt_d = rel_cnt; end
        else             cnt_d = cnt_q - FW'(1);
      end
      ST_DELAY: begin
        if (cnt_q != '0) cnt_d = cnt_q - FW'(1);
        else if (start_ok) begin
          st_d = start_st; cnt_d = start_cnt; act_ld = 1'b1;
        end else st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_ld) act_q <= sel;
  end

  assign busy     = (st_q == ST_SETUP) || (st_q == ST_RUN) ||
                    (st_q == ST_GAP)   || (st_q == ST_HOLD);
  assign clk_go   = (st_q == ST_RUN);
  assign act_port = act_q;

  // checker counters: cycles asserted, cycles released, last delay seen
  logic [AGEW-1:0] on_age_q, off_age_q;
  logic            went_q;
  logic [FW-1:0]   dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_age_q  <= '0;
      off_age_q <= '1;
      went_q    <= 1'b0;
      dly_q     <= '0;
    end else if (busy) begin
      if (on_age_q != '1) on_age_q <= on_age_q + AGEW'(1);
      off_age_q <= '0;
      dly_q     <= delay;
      if (clk_go) went_q <= 1'b1;
    end else begin
      on_age_q <= '0;
      went_q   <= 1'b0;
      if (off_age_q != '1) off_age_q <= off_age_q + AGEW'(1);
    end
  end

  // R4: first clocking cycle arrives exactly setup cycles after select
  assert_setup_len_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (clk_go && !went_q) |-> (on_age_q == AGEW'(setup)));

  // R6: a new assertion respects the previous minimum inactive time
  assert_inactive_min_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (off_age_q >= AGEW'(dly_q)));

  // R8: latched port cannot change while a select is held
  assert_port_latched_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act_q));
endmodule

// File: rtl/spi_cst_pins.sv
module spi_cst_pins #(
  parameter int NPORTS = 5,
  parameter int SELW   = 3
) (
  input  logic              busy,
  input  logic [SELW-1:0]   act_port,
  input  logic [SELW-1:0]   cur_port,
  input  logic [NPORTS-1:0] cs_idle,
  input  logic [NPORTS-1:0] ck_idle,
  input  logic [NPORTS-1:0] ck_phase,
  input  logic [NPORTS-1:0] d_idle,
  output logic [NPORTS-1:0] cs_o,
  output logic              sclk_idle,
  output logic              sclk_phase,
  output logic              data_idle
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_cs
    logic drive;
    assign drive   = busy && (act_port == SELW'(p));
    assign cs_o[p] = drive ? ~cs_idle[p] : cs_idle[p];
  end

  always_comb begin
    sclk_idle  = 1'b0;
    sclk_phase = 1'b0;
    data_idle  = 1'b0;
    for (int p = 0; p < NPORTS; p++) begin
      if (cur_port == SELW'(p)) begin
        sclk_idle  = ck_idle[p];
        sclk_phase = ck_phase[p];
        data_idle  = d_idle[p];
      end
    end
  end
endmodule

// File: rtl/spi_cs_timer.sv
module spi_cs_timer
  import spi_cst_pkg::*;
#(
  parameter int NPORTS = 5,
  parameter int SELW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SELW-1:0]   cfg_port,
  input  logic [31:0]       cfg_wdata,
  input  logic              st_we,
  input  logic [31:0]       st_wdata,
  input  logic              txn_req,
  input  logic              byte_done,
  input  logic              last_done,
  input  logic              gap_en,
  output logic [NPORTS-1:0] cs_o,
  output logic              clk_go,
  output logic              sclk_idle,
  output logic              sclk_phase,
  output logic              data_idle,
  output logic [7:0]        rate_sel,
  output logic              rate_ok
);
  port_param_t [NPORTS-1:0] prm;
  port_param_t              cur_prm;
  logic [SELW-1:0]          sel, act_port, cur_port;
  logic [NPORTS-1:0]        ck_idle, ck_phase, cs_idle, d_idle;
  logic                     busy;

  spi_cst_regs #(.NPORTS(NPORTS), .SELW(SELW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_wdata(port_param_t'(cfg_wdata)),
    .st_we(st_we), .st_wdata(st_wdata),
    .prm(prm), .sel(sel),
    .ck_idle(ck_idle), .ck_phase(ck_phase), .cs_idle(cs_idle), .d_idle(d_idle)
  );

  // the latched port governs while a select is held, the selector otherwise
  assign cur_port = busy ? act_port : sel;

  always_comb begin
    cur_prm = '0;
    for (int p = 0; p < NPORTS; p++)
      if (cur_port == SELW'(p)) cur_prm = prm[p];
  end

  spi_cst_seq #(.NPORTS(NPORTS), .SELW(SELW)) seq_i (
    .clk(clk), .rst_n(rst_n), .req(txn_req), .sel(sel),
    .setup(cur_prm.setup), .hold(cur_prm.hold), .delay(cur_prm.delay),
    .byte_done(byte_done), .last_done(last_done), .gap_en(gap_en),
    .busy(busy), .clk_go(clk_go), .act_port(act_port)
  );

  spi_cst_pins #(.NPORTS(NPORTS), .SELW(SELW)) pins_i (
    .busy(busy), .act_port(act_port), .cur_port(cur_port),
    .cs_idle(cs_idle), .ck_idle(ck_idle), .ck_phase(ck_phase), .d_idle(d_idle),
    .cs_o(cs_o), .sclk_idle(sclk_idle), .sclk_phase(sclk_phase), .data_idle(data_idle)
  );

  assign rate_sel = cur_prm.rate;
  assign rate_ok  = (cur_prm.rate != '0) &&
                    ((cur_prm.rate & (cur_prm.rate - FW'(1))) == '0);

  // R2: at most one line away from its idle level
  assert_one_select_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ cs_idle));

  // R4: clocking only while some select is active
  assert_go_needs_cs_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    clk_go |-> ((cs_o ^ cs_idle) != '0));
endmodule

// File: tb/spi_cs_timer_tb_top.sv
module spi_cs_timer_tb_top;
  localparam int N = 5;
  localparam logic [N-1:0] CKI = 5'b01100;
  localparam logic [N-1:0] PHS = 5'b01010;
  localparam logic [N-1:0] CSI = 5'b11011;
  localparam logic [N-1:0] DIL = 5'b10010;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_we, st_we, txn_req, byte_done, last_done, gap_en;
  logic [2:0] cfg_port;
  logic [31:0] cfg_wdata, st_wdata;
  logic [N-1:0] cs_o;
  logic clk_go, sclk_idle, sclk_phase, data_idle, rate_ok;
  logic [7:0] rate_sel;

  spi_cs_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_wdata(cfg_wdata), .st_we(st_we), .st_wdata(st_wdata),
    .txn_req(txn_req), .byte_done(byte_done), .last_done(last_done),
    .gap_en(gap_en), .cs_o(cs_o), .clk_go(clk_go), .sclk_idle(sclk_idle),
    .sclk_phase(sclk_phase), .data_idle(data_idle), .rate_sel(rate_sel),
    .rate_ok(rate_ok)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk_st(input int s);
    logic [31:0] w = '0;
    w[22:20] = 3'(s);
    for (int p = 0; p < N; p++) begin
      w[19-p] = CKI[p];
      w[14-p] = PHS[p];
      w[9-p]  = CSI[p];
      w[4-p]  = DIL[p];
    end
    return w;
  endfunction

  function automatic logic [N-1:0] exp_cs(input int p, input bit act);
    return act ? (CSI ^ N'(1 << p)) : CSI;
  endfunction

  function automatic bit asserted(input int p);
    return cs_o[p] != CSI[p];
  endfunction

  task automatic wr_cfg(input int p, input int rt, input int su, input int ho, input int dl);
    cfg_port = 3'(p);
    cfg_wdata = {8'(rt), 8'(su), 8'(ho), 8'(dl)};
    cfg_we = 1'b1; step(); cfg_we = 1'b0;
  endtask

  task automatic wr_st(input int s);
    st_wdata = mk_st(s);
    st_we = 1'b1; step(); st_we = 1'b0;
  endtask

  task automatic wait_go();
    for (int i = 0; i < 300 && !clk_go; i++) step();
  endtask

  task automatic finish_txn(input int p);
    wait_go();
    last_done = 1'b1; step(); last_done = 1'b0;
    for (int i = 0; i < 300 && asserted(p); i++) step();
    repeat (8) step();
  endtask

  task automatic run_txn(input int p, input int su, input int ho, input int dl, input bit gap);
    int n;
    gap_en = gap;
    txn_req = 1'b1; step();
    chk(cs_o == exp_cs(p, 1), "R2 select line", int'(cs_o), int'(exp_cs(p, 1)));
    txn_req = 1'b0;
    n = 0;
    while (!clk_go && n < 300) begin n++; step(); end
    chk(n == su, "R4 setup cycles", n, su);
    chk({sclk_idle, sclk_phase, data_idle} == {CKI[p], PHS[p], DIL[p]},
        "R3 port levels", int'({sclk_idle, sclk_phase, data_idle}),
        int'({CKI[p], PHS[p], DIL[p]}));
    for (int b = 0; b < 2; b++) begin
      step();
      byte_done = 1'b1; step(); byte_done = 1'b0;
      n = 0;
      while (!clk_go && n < 300) begin n++; step(); end
      chk(n == (gap ? ho : 0), "R7 byte gap", n, gap ? ho : 0);
    end
    last_done = 1'b1; step(); last_done = 1'b0;
    n = 0;
    while (asserted(p) && n < 300) begin
      if (clk_go) n = 1000;
      n++; step();
    end
    chk(n == ho, "R5 hold cycles", n, ho);
    txn_req = 1'b1;
    n = 0;
    while (!asserted(p) && n < 300) begin n++; step(); end
    chk(n == ((dl > 1) ? dl : 1), "R6 inactive cycles", n, (dl > 1) ? dl : 1);
    txn_req = 1'b0;
    finish_txn(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int su_set[3] = '{0, 1, 3};
    int ho_set[2] = '{0, 2};
    int dl_set[3] = '{0, 1, 4};
    rst_n = 1'b0; cfg_we = 0; st_we = 0; txn_req = 0; byte_done = 0;
    last_done = 0; gap_en = 0; cfg_port = '0; cfg_wdata = '0; st_wdata = '0;
    repeat (5) step();
    rst_n = 1'b1; step();
    // R1 reset state
    chk(cs_o == 5'b11111, "R1 reset cs", int'(cs_o), 31);
    chk(clk_go == 1'b0, "R1 reset clk_go", int'(clk_go), 0);
    chk(rate_sel == 8'd0, "R1 reset fields", int'(rate_sel), 0);

    wr_st(0);
    chk(cs_o == CSI, "R3 idle cs pattern", int'(cs_o), int'(CSI));

    // sweep ports and timing values
    for (int p = 0; p < N; p++) begin
      wr_st(p);
      for (int a = 0; a < 3; a++)
        for (int h = 0; h < 2; h++)
          for (int d = 0; d < 3; d++) begin
            wr_cfg(p, 4, su_set[a], ho_set[h], dl_set[d]);
            wr_cfg((p + 1) % N, 4, 7, 7, 7);
            run_txn(p, su_set[a], ho_set[h], dl_set[d], 1'((a + d + p) % 2));
          end
    end

    // R8 selector change during a transaction
    wr_st(1);
    wr_cfg(1, 4, 1, 1, 1);
    wr_cfg(3, 4, 2, 1, 1);
    txn_req = 1'b1; step(); txn_req = 1'b0;
    wait_go();
    wr_st(3);
    chk(cs_o == exp_cs(1, 1), "R8 port kept", int'(cs_o), int'(exp_cs(1, 1)));
    finish_txn(1);
    txn_req = 1'b1; step(); txn_req = 1'b0;
    chk(cs_o == exp_cs(3, 1), "R8 next port", int'(cs_o), int'(exp_cs(3, 1)));
    finish_txn(3);

    // R2 selector values with no port
    for (int s = 5; s < 8; s++) begin
      int seen;
      wr_st(s);
      txn_req = 1'b1;
      seen = 0;
      for (int i = 0; i < 10; i++) begin
        step();
        if (cs_o != CSI || clk_go) seen++;
      end
      txn_req = 1'b0;
      chk(seen == 0, "R2 invalid selector", seen, 0);
    end

    // R9 rate field sweep on port 2
    wr_st(2);
    for (int v = 0; v < 256; v++) begin
      bit pw;
      pw = 1'b0;
      for (int k = 0; k < 8; k++) if (v == (1 << k)) pw = 1'b1;
      wr_cfg(2, v, 0, 0, 0);
      chk(rate_sel == 8'(v), "R9 rate value", int'(rate_sel), v);
      chk(rate_ok == pw, "R9 rate legality", int'(rate_ok), int'(pw));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule